// File: doc/BRIEF.md
# Hamming Single-Error-Correct / Double-Error-Detect Decoder

This block checks a systematic Hamming codeword and returns its message, either corrected or passed through, one clock later. The message width is a parameter. The number of check bits and the parity-check structure are derived from that width at elaboration time.

Two build-time switches set the mode. `XPAR` adds an overall even-parity bit. `CORR` turns correction on. Together they give four behaviours:

| XPAR | CORR | Behaviour |
|------|------|-----------|
| 0 | 0 | Detects single and double errors |
| 0 | 1 | Corrects single errors |
| 1 | 0 | Detects single, double and triple errors |
| 1 | 1 | Corrects single errors and detects double errors |

The input is a stream beat qualified by `in_valid`. The output beat is qualified by `out_valid`. There is no ready signal and no back-pressure, so the consumer must take every beat in the cycle it appears. A cycle with `in_valid` low produces an empty output beat: all outputs read zero.

Top module: `hd_decoder`

## Requirements
- R1: While `rst` is high, `out_valid`, `out_msg`, `out_fixed` and `out_err` are all zero. The reset is asynchronous and active high, so the outputs clear without waiting for a clock edge.
- R2: A rising clock edge that samples `in_valid` low clears `out_valid`, `out_msg`, `out_fixed` and `out_err`, whatever is on the data inputs.
- R3: A rising clock edge that samples `in_valid` high raises `out_valid` and presents the result for the sampled inputs. The result appears after that same edge and holds until the next edge.
- R4: Codeword layout:
  - The first R check bits are `in_chk[R-1:0]`. R is the smallest value with 2^R >= MSG_W + R + 1.
  - Message bit i takes the i-th Hamming position that is not a power of two. These positions are 3, 5, 6, 7, 9, 10, 11, 12 and so on.
  - Check bit j equals the XOR of the message bits whose position has bit j set.
  - With `XPAR` = 1, `in_chk[R]` makes the XOR of all message and check bits zero.
  - Positions beyond the last message bit count as zero.
- R5: A valid codeword gives `out_msg` equal to `in_msg`, with `out_fixed` and `out_err` both low, in every mode.
- R6: With `CORR` = 0, `out_msg` always equals the sampled `in_msg` and `out_fixed` stays low.
- R7: With `XPAR` = 0 and `CORR` = 0, any 1-bit or 2-bit error raises `out_err`.
- R8: With `XPAR` = 1 and `CORR` = 0, any error of 1, 2 or 3 bits raises `out_err`.
- R9: With `XPAR` = 0 and `CORR` = 1, a single-bit error anywhere in the codeword restores the original message. It raises `out_fixed` and leaves `out_err` low.
- R10: With `XPAR` = 1 and `CORR` = 1:
  - A single-bit error restores the message and raises `out_fixed`. This includes an error in the overall bit alone, which leaves the data untouched.
  - A double error raises `out_err`, keeps `out_fixed` low and passes the message unchanged.
- R11: In both correcting modes, a word that is not a codeword and is not handled as in R10 is decoded to the codeword at distance one, if one exists. That codeword's data is output and `out_fixed` is raised. So a triple error in the XPAR=1, CORR=1 mode is silently miscorrected. If no codeword lies at distance one (the syndrome names an unused position), `out_err` is raised and the message passes unchanged.
- R12: `out_fixed` and `out_err` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| in_valid | input | 1 | Input beat qualifier; low produces an empty output beat |
| in_msg | input | MSG_W | Received message bits |
| in_chk | input | R + XPAR | Received check bits, with the overall parity bit on top when present |
| out_valid | output | 1 | Output beat qualifier |
| out_msg | output | MSG_W | Corrected or passed-through message |
| out_fixed | output | 1 | The beat carried an error that was corrected |
| out_err | output | 1 | The beat carried an error that was detected but not corrected |

## Verification
Every result is due exactly one rising edge after its inputs are sampled: the message, both flags and `out_valid`. The only exception is reset, which clears the outputs at once.

The bench drives each beat on a falling edge and reads all four mode instances at the next falling edge, half a period after the edge that registered the result. Reset values are read 1 ns after `rst` rises, with no clock edge in between.

Each beat is followed immediately by the next, so any extra or missing pipeline stage shows up as a misaligned message.

// File: rtl/hd_pkg.sv
package hd_pkg;

  // Smallest r with 2^r >= msg_w + r + 1
  function automatic int chk_bits(input int msg_w);
    int r;
    r = 31;
    for (int k = 30; k >= 1; k--) begin
      if ((64'd1 << k) >= 64'(msg_w) + 64'(k) + 64'd1) r = k;
    end
    return r;
  endfunction

  // Hamming position (1-based) of message bit i: skips the powers of two
  function automatic int data_pos(input int i);
    int p;
    p = i + 1;
    for (int k = 0; k < 16; k++) begin
      if ((1 << k) <= p) p++;
    end
    return p;
  endfunction

endpackage

// File: rtl/hd_syndrome.sv
module hd_syndrome
  import hd_pkg::*;
#(
  parameter int MSG_W = 8,
  parameter int R     = 4,
  parameter bit XPAR  = 1'b1,
  localparam int CHK_W = R + int'(XPAR)
) (
  input  logic [MSG_W-1:0] msg,
  input  logic [CHK_W-1:0] chk,
  output logic [R-1:0]     syn,
  output logic             par_bad
);

  // One parity-check row per syndrome bit
  for (genvar j = 0; j < R; j++) begin : g_row
    logic [MSG_W-1:0] sel;
    for (genvar i = 0; i < MSG_W; i++) begin : g_bit
      localparam int POS = data_pos(i);
      if (((POS >> j) & 1) != 0) begin : g_on
        assign sel[i] = msg[i];
      end else begin : g_off
        assign sel[i] = 1'b0;
      end
    end
    assign syn[j] = chk[j] ^ (^sel);
  end

  if (XPAR) begin : g_xp
    assign par_bad = ^{chk, msg};
  end else begin : g_nxp
    assign par_bad = 1'b0;
  end

endmodule

// File: rtl/hd_fix.sv
module hd_fix
  import hd_pkg::*;
#(
  parameter int MSG_W = 8,
  parameter int R     = 4,
  parameter bit XPAR  = 1'b1,
  parameter bit CORR  = 1'b1
) (
  input  logic [MSG_W-1:0] msg,
  input  logic [R-1:0]     syn,
  input  logic             par_bad,
  output logic [MSG_W-1:0] msg_out,
  output logic             fixed,
  output logic             err
);

  logic syn_nz;
  assign syn_nz = |syn;

  if (!CORR) begin : g_detect
    assign msg_out = msg;
    assign fixed   = 1'b0;
    assign err     = syn_nz | par_bad;
  end else begin : g_correct
    localparam logic [R-1:0] TOP = R'(data_pos(MSG_W - 1));
    logic [MSG_W-1:0] flip;
    logic             in_range;
    logic             single;

    for (genvar i = 0; i < MSG_W; i++) begin : g_flip
      localparam logic [R-1:0] PV = R'(data_pos(i));
      assign flip[i] = (syn == PV);
    end

    assign in_range = (syn <= TOP);
    // With the overall bit, an odd count of flips marks a correctable word
    assign single = XPAR ? par_bad : syn_nz;

    always_comb begin
      msg_out = msg;
      fixed   = 1'b0;
      err     = 1'b0;
      if (single) begin
        if (!syn_nz) begin
          fixed = 1'b1;
        end else if (in_range) begin
          fixed   = 1'b1;
          msg_out = msg ^ flip;
        end else begin
          err = 1'b1;
        end
      end else if (syn_nz) begin
        err = 1'b1;
      end
    end
  end

endmodule

// File: rtl/hd_outreg.sv
module hd_outreg #(
  parameter int MSG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [MSG_W-1:0] d_msg,
  input  logic             d_fixed,
  input  logic             d_err,
  output logic             q_valid,
  output logic [MSG_W-1:0] q_msg,
  output logic             q_fixed,
  output logic             q_err
);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      q_valid <= 1'b0;
      q_msg   <= '0;
      q_fixed <= 1'b0;
      q_err   <= 1'b0;
    end else if (!en) begin
      q_valid <= 1'b0;
      q_msg   <= '0;
      q_fixed <= 1'b0;
      q_err   <= 1'b0;
    end else begin
      q_valid <= 1'b1;
      q_msg   <= d_msg;
      q_fixed <= d_fixed;
      q_err   <= d_err;
    end
  end

endmodule

// File: rtl/hd_decoder.sv
module hd_decoder
  import hd_pkg::*;
#(
  parameter int MSG_W = 8,
  parameter bit XPAR  = 1'b1,
  parameter bit CORR  = 1'b1,
  localparam int R     = chk_bits(MSG_W),
  localparam int CHK_W = R + int'(XPAR)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [MSG_W-1:0] in_msg,
  input  logic [CHK_W-1:0] in_chk,
  output logic             out_valid,
  output logic [MSG_W-1:0] out_msg,
  output logic             out_fixed,
  output logic             out_err
);

  logic [R-1:0]     syn;
  logic             par_bad;
  logic [MSG_W-1:0] dec_msg;
  logic             dec_fixed;
  logic             dec_err;

  hd_syndrome #(.MSG_W(MSG_W), .R(R), .XPAR(XPAR)) u_syn (
    .msg     (in_msg),
    .chk     (in_chk),
    .syn     (syn),
    .par_bad (par_bad)
  );

  hd_fix #(.MSG_W(MSG_W), .R(R), .XPAR(XPAR), .CORR(CORR)) u_fix (
    .msg     (in_msg),
    .syn     (syn),
    .par_bad (par_bad),
    .msg_out (dec_msg),
    .fixed   (dec_fixed),
    .err     (dec_err)
  );

  hd_outreg #(.MSG_W(MSG_W)) u_out (
    .clk     (clk),
    .rst     (rst),
    .en      (in_valid),
    .d_msg   (dec_msg),
    .d_fixed (dec_fixed),
    .d_err   (dec_err),
    .q_valid (out_valid),
    .q_msg   (out_msg),
    .q_fixed (out_fixed),
    .q_err   (out_err)
  );

endmodule

// File: rtl/hd_decoder_chk.sv
module hd_decoder_chk #(
  parameter int MSG_W = 8,
  parameter bit CORR  = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [MSG_W-1:0] in_msg,
  input logic             out_valid,
  input logic [MSG_W-1:0] out_msg,
  input logic             out_fixed,
  input logic             out_err
);

  always @(posedge clk) begin
    if (rst) begin
      // R1
      reset_quiet_chk: assert (!out_valid && out_msg == '0 && !out_fixed && !out_err)
        else $error("outputs not cleared during reset");
    end
  end

  // R2
  idle_clears_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && out_msg == '0 && !out_fixed && !out_err));

  // R3
  one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R12
  flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(out_fixed && out_err));

  if (!CORR) begin : g_det
    // R6
    passthru_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> (out_msg == $past(in_msg) && !out_fixed));
  end else begin : g_cor
    // R9
    one_flip_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> ($countones(out_msg ^ $past(in_msg)) <= 1));
    // R11
    change_flagged_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> (out_msg == $past(in_msg) || out_fixed));
  end

endmodule

bind hd_decoder hd_decoder_chk #(.MSG_W(MSG_W), .CORR(CORR)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_msg    (in_msg),
  .out_valid (out_valid),
  .out_msg   (out_msg),
  .out_fixed (out_fixed),
  .out_err   (out_err)
);

// File: tb/tb_hd_decoder.sv
module tb_hd_decoder;
  localparam int MSG_W = 8;
  // Known codewords {overall, chk[3:0], msg[7:0]} for MSG_W = 8 (R4)
  localparam logic [12:0] TBL [6] = '{
    {5'b00000, 8'h00}, {5'b10011, 8'h01}, {5'b11100, 8'h80},
    {5'b10101, 8'h02}, {5'b00110, 8'h03}, {5'b00011, 8'hFF}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [12:0] rx = '0;
  logic [3:0] o_val, o_fix, o_err;
  logic [MSG_W-1:0] o_msg [4];
  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  // mode m: XPAR = m / 2, CORR = m % 2
  for (genvar m = 0; m < 4; m++) begin : g_mode
    localparam bit XP = (m >= 2);
    localparam bit CR = ((m % 2) == 1);
    localparam int CW = 4 + (XP ? 1 : 0);
    logic [CW-1:0] chk_in;
    assign chk_in = rx[8 +: CW];
    hd_decoder #(.MSG_W(MSG_W), .XPAR(XP), .CORR(CR)) dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_msg(rx[7:0]), .in_chk(chk_in),
      .out_valid(o_val[m]), .out_msg(o_msg[m]), .out_fixed(o_fix[m]), .out_err(o_err[m])
    );
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++;
      n_fail++;
      $display("FAIL R3 watchdog: actual=%0d cycles expected=<100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  function automatic int bpos(input int i);
    int cnt = -1;
    int res = 0;
    for (int p = 1; p < 32; p++) begin
      if ((p & (p - 1)) != 0) begin
        cnt++;
        if (cnt == i) res = p;
      end
    end
    return res;
  endfunction

  function automatic logic [4:0] enc(input logic [7:0] d);
    logic [3:0] s = '0;
    for (int i = 0; i < 8; i++) if (d[i]) s = s ^ 4'(bpos(i));
    return {^{d, s}, s};
  endfunction

  function automatic bit is_cw(input logic [12:0] w, input bit xp);
    logic [4:0] c = enc(w[7:0]);
    if (xp) return w[12:8] == c;
    return w[11:8] == c[3:0];
  endfunction

  task automatic model(input int m, input logic [12:0] w,
                       output logic [7:0] em, output logic ef, output logic ee);
    bit xp = (m >= 2);
    bit cr = ((m % 2) == 1);
    logic [12:0] rv = xp ? w : (w & 13'h0fff);
    logic [12:0] t;
    int nb = xp ? 13 : 12;
    bit found = 0;
    em = rv[7:0];
    ef = 1'b0;
    ee = 1'b0;
    if (is_cw(rv, xp)) return;
    if (!cr || (xp && (^rv == 1'b0))) begin
      ee = 1'b1;
      return;
    end
    for (int b = 0; b < nb; b++) begin
      t = rv ^ (13'd1 << b);
      if (!found && is_cw(t, xp)) begin
        found = 1;
        em = t[7:0];
      end
    end
    if (found) ef = 1'b1;
    else ee = 1'b1;
  endtask

  task automatic check(input string req, input int m, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s mode %0d: actual=%0h expected=%0h", req, m, act, exp);
    end
  endtask

  task automatic apply(input logic [12:0] w, input logic v);
    rx = w;
    in_valid = v;
    @(negedge clk);
  endtask

  function automatic string tag(input int m, input int wt);
    if (wt == 0) return "R5";
    if (m == 0) return "R7";
    if (m == 2) return "R8";
    if (m == 1) return (wt == 1) ? "R9" : "R11";
    return (wt <= 2) ? "R10" : "R11";
  endfunction

  task automatic check_zero(input string req);
    for (int m = 0; m < 4; m++) begin
      check(req, m, {o_val[m], o_fix[m], o_err[m]}, 0);
      check(req, m, o_msg[m], 0);
    end
  endtask

  task automatic check_one(input int m, input string req, input logic [7:0] em,
                           input logic ef, input logic ee);
    check("R3", m, o_val[m], 1);
    check(req, m, o_msg[m], em);
    check(req, m, o_fix[m], ef);
    check(req, m, o_err[m], ee);
    check("R12", m, o_fix[m] & o_err[m], 0);
  endtask

  initial begin
    logic [7:0] em;
    logic ef, ee;
    #1;
    check_zero("R1");
    repeat (2) @(negedge clk);
    rst = 1'b0;

    // Walk the known codewords: clean in every mode (R4, R5)
    for (int t = 0; t < 6; t++) begin
      apply(TBL[t], 1'b1);
      for (int m = 0; m < 4; m++) check_one(m, "R4", TBL[t][7:0], 1'b0, 1'b0);
    end

    // Every error pattern of weight up to three on each codeword
    for (int t = 0; t < 6; t++) begin
      for (int mk = 0; mk < 8192; mk++) begin
        if ($countones(mk) <= 3) begin
          apply(TBL[t] ^ 13'(mk), 1'b1);
          for (int m = 0; m < 4; m++) begin
            int wt = (m >= 2) ? $countones(mk) : $countones(mk & 32'hfff);
            model(m, TBL[t] ^ 13'(mk), em, ef, ee);
            check_one(m, ((m % 2) == 0 && wt != 0) ? "R6" : tag(m, wt), em, ef, ee);
            check(tag(m, wt), m, {o_fix[m], o_err[m]}, {ef, ee});
          end
        end
      end
    end

    // Directed corner cases, XPAR=1 CORR=1 (mode 3)
    apply(TBL[0] ^ 13'h007, 1'b1);   // syndrome 3^5^6 = 0: miscorrected as overall-bit error
    check_one(3, "R11", 8'h07, 1'b1, 1'b0);
    apply(TBL[0] ^ 13'h805, 1'b1);   // syndrome 13, unused position
    check_one(3, "R11", 8'h05, 1'b0, 1'b1);
    check_one(1, "R11", 8'h05, 1'b0, 1'b1);
    apply(TBL[5] ^ 13'h1000, 1'b1);  // overall bit alone
    check_one(3, "R10", 8'hFF, 1'b1, 1'b0);
    check_one(2, "R8", 8'hFF, 1'b0, 1'b1);

    // Idle beats clear everything, even with erroneous data (R2)
    apply(TBL[1] ^ 13'h003, 1'b1);
    apply(TBL[2], 1'b0);
    check_zero("R2");
    apply(TBL[3] ^ 13'h001, 1'b0);
    check_zero("R2");

    // Back-to-back beats stay aligned (R3)
    apply(TBL[4], 1'b1);
    for (int m = 0; m < 4; m++) check_one(m, "R3", 8'h03, 1'b0, 1'b0);
    apply(TBL[5], 1'b1);
    for (int m = 0; m < 4; m++) check_one(m, "R3", 8'hFF, 1'b0, 1'b0);

    // Asynchronous reset mid-stream (R1)
    rst = 1'b1;
    #1;
    check_zero("R1");
    @(negedge clk);
    check_zero("R1");
    rst = 1'b0;
    apply(TBL[1], 1'b1);
    for (int m = 0; m < 4; m++) check_one(m, "R5", 8'h01, 1'b0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule